// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an asynchronous 16-bit static RAM. The RAM has a low-active and a high-active chip select, a write strobe, an output enable and one enable per byte lane. The host issues one request at a time with a ready/request handshake. The request carries a write flag, a 20-bit word address, 16-bit write data and a two-bit byte mask. The controller turns the request into a timed strobe sequence. It returns read data together with a one-cycle valid pulse.

Every phase length is derived from the clock period, given as a parameter in nanoseconds. A phase lasts the ceiling of its nanosecond limit divided by the period, plus one margin cycle. With the default 4 ns clock this gives the following lengths:

| Quantity | Limit | Cycles |
|---|---|---|
| Read wait (N_RD, from the larger of the 45 ns cycle and the 22 ns output-enable limits) | 45 ns | 13 |
| Turnaround (N_TA, 18 ns) | 18 ns | 6 |
| Write pulse (N_WP, 35 ns) | 35 ns | 10 |
| Setup | — | 1 |

A per-request flag selects a byte-wide organisation of the memory. In that mode:

- Only the low lane carries data.
- The top data pin is driven by the controller as the least-significant byte address.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and in idle, these outputs hold their inactive levels: mem_cs_n=1, mem_cs=0, mem_we_n=1, mem_oe_n=1, mem_lane_n=2'b11. An asynchronous reset during a write drops all of these at once.
- R2: A read holds mem_we_n=1 and drives mem_oe_n=0. Only the requested lanes are driven low on mem_lane_n. Bit 0 of the mask and of mem_lane_n is the low lane (data bits 7:0), and bit 1 is the high lane (bits 15:8). mem_we_n and mem_oe_n are never low together.
- R3: mem_oe_n stays low for exactly N_RD+1 cycles, after one setup cycle. Read data is captured at the end of the last of these cycles, and host_rvalid rises in the same cycle that mem_oe_n rises.
- R4: After mem_oe_n rises, host_ready returns only after N_TA cycles. During this window the chip select is inactive and the controller drives no data.
- R5: mem_addr equals the accepted address from the setup cycle to the end of the sequence. It changes only when a request is accepted.
- R6: A write proceeds in four steps:
  - one setup cycle with the select and lanes active and mem_we_n=1;
  - mem_we_n=0 for exactly N_WP cycles, with the write data on the requested lanes;
  - one hold cycle with mem_we_n=1, the select still active, and the data and address unchanged;
  - return to idle.
- R7: A request with mask 2'b00 never drives any lane low. As a read, it returns host_rdata=0. As a write, it leaves the memory unchanged.
- R8: In read data, lanes that were not requested are zero. host_rvalid is high for exactly one cycle per read.
- R9: host_ready is high only in idle. A request is taken on a clock edge where host_req and host_ready are both high.
- R10: With host_mode8=1 the transfer uses only the low lane (mem_lane_n=2'b10).
  - mem_dq[15] carries the byte select: 1 when the mask is 2'b10, else 0. With mask 2'b11 the low byte wins.
  - A write takes its byte from the host lane the mask selects.
  - A read returns the byte in that same host lane, with the other lane zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Request strobe |
| host_ready | output | 1 | High when a request can be taken |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Byte mask, bit 0 = low lane |
| host_mode8 | input | 1 | Byte-wide memory organisation for this request |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | One-cycle read-data valid |
| mem_addr | output | 20 | Memory address |
| mem_cs_n | output | 1 | Low-active chip select |
| mem_cs | output | 1 | High-active chip select |
| mem_we_n | output | 1 | Write strobe, low-active |
| mem_oe_n | output | 1 | Output enable, low-active |
| mem_lane_n | output | 2 | Lane enables, low-active, bit 0 = low lane |
| mem_dq | inout | 16 | Tri-stated memory data |

## Verification
The bench targets three timing corner cases:

- The exact output-enable and write-strobe lengths. A phase counter that is off by one would shorten the read window below the access time, or lengthen the write pulse.
- The turnaround gap before ready returns. A controller that skipped it would clash with the memory's still-driving outputs.
- The hold cycle after the write strobe rises. Without it the written data would be lost or wrong.

It also targets the mask and mode corners:

- A zero mask, which a careless decoder would turn into an asserted lane.
- Partial masks, whose unrequested lanes would leak stale bus bits.
- The byte-wide mode, where a wrong byte select on the top data pin would swap or corrupt bytes.
- A mask of 2'b11 in byte-wide mode, which must resolve to the low byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD_WAIT,
    ST_RD_CAP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_TURN
  } ctrl_state_t;

  // Phase length: ceiling of the limit over the clock period, plus one margin cycle.
  function automatic int unsigned phase_cycles(input int unsigned lim_ns,
                                               input int unsigned per_ns);
    return (lim_ns + per_ns - 1) / per_ns + 1;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int unsigned DW = 16
) (
  input  logic [1:0]    mask,
  input  logic          mode8,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rd_dq,
  output logic [1:0]    lane_n,
  output logic          byte_sel,
  output logic [DW-1:0] wr_bus,
  output logic [DW-1:0] rd_word
);

  localparam int unsigned HALF = DW / 2;

  logic any_lane;

  assign any_lane = |mask;
  // Byte-wide mode picks the upper byte only when the low lane is not requested.
  assign byte_sel = mode8 && (mask == 2'b10);

  always_comb begin
    if (mode8) begin
      lane_n = any_lane ? 2'b10 : 2'b11;
    end else begin
      lane_n = ~mask;
    end
  end

  always_comb begin
    wr_bus = wdata;
    if (mode8) begin
      wr_bus[HALF-1:0] = byte_sel ? wdata[DW-1:HALF] : wdata[HALF-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    if (mode8) begin
      if (any_lane) begin
        if (byte_sel) begin
          rd_word[DW-1:HALF] = rd_dq[HALF-1:0];
        end else begin
          rd_word[HALF-1:0] = rd_dq[HALF-1:0];
        end
      end
    end else begin
      if (mask[0]) rd_word[HALF-1:0]  = rd_dq[HALF-1:0];
      if (mask[1]) rd_word[DW-1:HALF] = rd_dq[DW-1:HALF];
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap_en;
      if (cap_en) begin
        rdata <= rd_word;
      end
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 20,
  parameter int unsigned DW            = 16,
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned T_CYCLE_NS    = 45,
  parameter int unsigned T_OE_DATA_NS  = 22,
  parameter int unsigned T_RELEASE_NS  = 18,
  parameter int unsigned T_WPULSE_NS   = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  output logic          host_ready,
  input  logic          host_write,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [1:0]    host_mask,
  input  logic          host_mode8,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [1:0]    mem_lane_n,
  inout  wire  [DW-1:0] mem_dq
);

  localparam int unsigned HALF   = DW / 2;
  localparam int unsigned N_SU   = 1;
  localparam int unsigned N_RC   = phase_cycles(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned N_DOE  = phase_cycles(T_OE_DATA_NS, CLK_PERIOD_NS);
  localparam int unsigned N_RD   = (N_RC > N_DOE) ? N_RC : N_DOE;
  localparam int unsigned N_TA   = phase_cycles(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned N_WP   = phase_cycles(T_WPULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned N_MAX1 = (N_RD > N_WP) ? N_RD : N_WP;
  localparam int unsigned N_MAX  = (N_MAX1 > N_TA) ? N_MAX1 : N_TA;
  localparam int unsigned CNT_W  = $clog2(N_MAX + 1);

  localparam logic [CNT_W-1:0] LD_SU = CNT_W'(N_SU - 1);
  localparam logic [CNT_W-1:0] LD_RD = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LD_TA = CNT_W'(N_TA - 1);
  localparam logic [CNT_W-1:0] LD_WP = CNT_W'(N_WP - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  ctrl_state_t st_q, st_nxt;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  logic          rq_write;
  logic          rq_mode8;
  logic [AW-1:0] rq_addr;
  logic [DW-1:0] rq_wdata;
  logic [1:0]    rq_mask;

  assign host_ready = (st_q == ST_IDLE);
  assign accept     = host_req && host_ready;

  // Request registers, loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rq_write <= 1'b0;
      rq_mode8 <= 1'b0;
      rq_addr  <= '0;
      rq_wdata <= '0;
      rq_mask  <= '0;
    end else if (accept) begin
      rq_write <= host_write;
      rq_mode8 <= host_mode8;
      rq_addr  <= host_addr;
      rq_wdata <= host_wdata;
      rq_mask  <= host_mask;
    end
  end

  // Next state and timer load.
  always_comb begin
    st_nxt   = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_nxt   = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = LD_SU;
        end
      end
      ST_SETUP: begin
        if (tmr_done) begin
          st_nxt   = rq_write ? ST_WR_PULSE : ST_RD_WAIT;
          tmr_load = 1'b1;
          tmr_val  = rq_write ? LD_WP : LD_RD;
        end
      end
      ST_RD_WAIT: begin
        if (tmr_done) begin
          st_nxt   = ST_RD_CAP;
          tmr_load = 1'b1;
        end
      end
      ST_RD_CAP: begin
        st_nxt   = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = LD_TA;
      end
      ST_TURN: begin
        if (tmr_done) st_nxt = ST_IDLE;
      end
      ST_WR_PULSE: begin
        if (tmr_done) begin
          st_nxt   = ST_WR_HOLD;
          tmr_load = 1'b1;
        end
      end
      ST_WR_HOLD: begin
        st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_nxt;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  logic [1:0]    lane_n;
  logic          byte_sel;
  logic [DW-1:0] wr_bus;
  logic [DW-1:0] rd_word;

  sram_lane_map #(.DW(DW)) lanes_i (
    .mask     (rq_mask),
    .mode8    (rq_mode8),
    .wdata    (rq_wdata),
    .rd_dq    (mem_dq),
    .lane_n   (lane_n),
    .byte_sel (byte_sel),
    .wr_bus   (wr_bus),
    .rd_word  (rd_word)
  );

  sram_rd_capture #(.DW(DW)) cap_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .cap_en  (st_q == ST_RD_CAP),
    .rd_word (rd_word),
    .rdata   (host_rdata),
    .rvalid  (host_rvalid)
  );

  // Memory strobes, decoded from state.
  logic selected, drive_wr, en_lo, en_hi, en_top, top_val;

  assign selected = (st_q == ST_SETUP) || (st_q == ST_RD_WAIT) || (st_q == ST_RD_CAP)
                 || (st_q == ST_WR_PULSE) || (st_q == ST_WR_HOLD);
  assign drive_wr = (st_q == ST_WR_PULSE) || (st_q == ST_WR_HOLD);

  assign mem_addr   = rq_addr;
  assign mem_cs_n   = !selected;
  assign mem_cs     = selected;
  assign mem_lane_n = selected ? lane_n : 2'b11;
  assign mem_oe_n   = !((st_q == ST_RD_WAIT) || (st_q == ST_RD_CAP));
  assign mem_we_n   = (st_q != ST_WR_PULSE);

  assign en_lo   = drive_wr && !lane_n[0];
  assign en_hi   = drive_wr && !lane_n[1] && !rq_mode8;
  assign en_top  = rq_mode8 ? selected : en_hi;
  assign top_val = rq_mode8 ? byte_sel : wr_bus[DW-1];

  assign mem_dq[HALF-1:0]    = en_lo  ? wr_bus[HALF-1:0]    : {HALF{1'bz}};
  assign mem_dq[DW-2:HALF]   = en_hi  ? wr_bus[DW-2:HALF]   : {(HALF-1){1'bz}};
  assign mem_dq[DW-1]        = en_top ? top_val             : 1'bz;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req,
  input logic          host_ready,
  input logic [1:0]    host_mask,
  input logic          host_rvalid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_cs,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [1:0]    mem_lane_n
);

  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && mem_lane_n == 2'b11)); // R9

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R2

  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_cs_n && mem_cs)); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R5

  AST_ZERO_MASK_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_ready && host_mask == 2'b00) |=> (mem_lane_n == 2'b11)); // R7

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid); // R8

  AST_VALID_WITH_OE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> host_rvalid); // R3

  AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n && $stable(mem_addr))); // R6

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .host_req    (host_req),
  .host_ready  (host_ready),
  .host_mask   (host_mask),
  .host_rvalid (host_rvalid),
  .mem_addr    (mem_addr),
  .mem_cs_n    (mem_cs_n),
  .mem_cs      (mem_cs),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n),
  .mem_lane_n  (mem_lane_n)
);

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;

  localparam int unsigned P    = 4;
  localparam int unsigned N_RD = (45 + P - 1) / P + 1;
  localparam int unsigned N_TA = (18 + P - 1) / P + 1;
  localparam int unsigned N_WP = (35 + P - 1) / P + 1;

  // {write, mode8, mask[1:0], addr[3:0], wdata[15:0], expected read[15:0]}
  localparam int NV = 16;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b11, 4'h1, 16'hA5C3, 16'h0000},
    {1'b0, 1'b0, 2'b11, 4'h1, 16'h0000, 16'hA5C3},
    {1'b0, 1'b0, 2'b01, 4'h1, 16'h0000, 16'h00C3},
    {1'b0, 1'b0, 2'b10, 4'h1, 16'h0000, 16'hA500},
    {1'b1, 1'b0, 2'b10, 4'h1, 16'h7700, 16'h0000},
    {1'b0, 1'b0, 2'b11, 4'h1, 16'h0000, 16'h77C3},
    {1'b1, 1'b0, 2'b00, 4'h1, 16'hFFFF, 16'h0000},
    {1'b0, 1'b0, 2'b11, 4'h1, 16'h0000, 16'h77C3},
    {1'b0, 1'b0, 2'b00, 4'h1, 16'h0000, 16'h0000},
    {1'b1, 1'b1, 2'b01, 4'h2, 16'h0011, 16'h0000},
    {1'b1, 1'b1, 2'b10, 4'h2, 16'h2200, 16'h0000},
    {1'b0, 1'b0, 2'b11, 4'h2, 16'h0000, 16'h2211},
    {1'b0, 1'b1, 2'b10, 4'h2, 16'h0000, 16'h2200},
    {1'b0, 1'b1, 2'b01, 4'h2, 16'h0000, 16'h0011},
    {1'b1, 1'b1, 2'b11, 4'h3, 16'h1234, 16'h0000},
    {1'b0, 1'b0, 2'b11, 4'h3, 16'h0000, 16'h0034}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_write = 1'b0;
  logic [19:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_mask = '0;
  logic        host_mode8 = 1'b0;
  logic        host_ready, host_rvalid;
  logic [15:0] host_rdata;
  logic [19:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n;
  logic [1:0]  mem_lane_n;
  wire  [15:0] mem_dq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic model_en = 1'b0;

  always #2 clk = ~clk;

  sram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_mask(host_mask), .host_mode8(host_mode8), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lane_n(mem_lane_n), .mem_dq(mem_dq)
  );

  // Memory model: 16 words, byte-wide view uses mem_dq[15] as byte select.
  logic [15:0] mem_w [16];
  logic [3:0]  ma;
  logic        act;
  logic [7:0]  rd_lo;
  assign ma  = mem_addr[3:0];
  assign act = model_en && !mem_cs_n && mem_cs;
  always_comb rd_lo = (host_mode8 && mem_dq[15]) ? mem_w[ma][15:8] : mem_w[ma][7:0];
  assign mem_dq[7:0]  = (act && !mem_oe_n && !mem_lane_n[0]) ? rd_lo : 8'hzz;
  assign mem_dq[15:8] = (act && !mem_oe_n && !mem_lane_n[1] && !host_mode8)
                        ? mem_w[ma][15:8] : 8'hzz;

  always @(posedge mem_we_n) begin
    if (act) begin
      if (host_mode8) begin
        if (mem_dq[15]) mem_w[ma][15:8] <= mem_dq[7:0];
        else            mem_w[ma][7:0]  <= mem_dq[7:0];
      end else begin
        if (!mem_lane_n[0]) mem_w[ma][7:0]  <= mem_dq[7:0];
        if (!mem_lane_n[1]) mem_w[ma][15:8] <= mem_dq[15:8];
      end
    end
  end

  // Strobe length monitor.
  int oe_run = 0, we_run = 0, last_oe = 0, last_we = 0;
  always @(negedge clk) begin
    if (!mem_oe_n) oe_run++;
    else begin
      if (oe_run != 0) last_oe = oe_run;
      oe_run = 0;
    end
    if (!mem_we_n) we_run++;
    else begin
      if (we_run != 0) last_we = we_run;
      we_run = 0;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic idle_levels(input string tag);
    chk(tag, "cs_n", 32'(mem_cs_n), 32'd1);
    chk(tag, "cs", 32'(mem_cs), 32'd0);
    chk(tag, "we_n", 32'(mem_we_n), 32'd1);
    chk(tag, "oe_n", 32'(mem_oe_n), 32'd1);
    chk(tag, "lane_n", 32'(mem_lane_n), 32'd3);
  endtask

  task automatic run_txn(input logic [39:0] v);
    logic        wr   = v[39];
    logic        m8   = v[38];
    logic [1:0]  mk   = v[37:36];
    logic [19:0] ad   = {16'h0, v[35:32]};
    logic [15:0] exp  = v[15:0];
    logic [1:0]  lexp;
    string       tag;
    int          n;
    lexp = m8 ? ((mk != 2'b00) ? 2'b10 : 2'b11) : ~mk;
    tag  = (mk == 2'b00) ? "R7" : (m8 ? "R10" : "R8");
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_write = wr; host_mode8 = m8; host_mask = mk;
    host_addr = ad; host_wdata = v[31:16];
    @(negedge clk);
    host_req = 1'b0;
    // Setup cycle.
    chk("R9", "ready while busy", 32'(host_ready), 32'd0);
    chk("R2", "lanes in setup", 32'(mem_lane_n), 32'(lexp));
    chk("R5", "address in setup", 32'(mem_addr), 32'(ad));
    chk("R6", "strobes idle in setup", 32'({mem_we_n, mem_oe_n}), 32'd3);
    if (m8) chk("R10", "byte select pin", 32'(mem_dq[15]), 32'(mk == 2'b10));
    if (wr) begin
      while (mem_we_n) @(negedge clk);
      while (!mem_we_n) @(negedge clk);
      chk("R6", "select held after we rise", 32'(mem_cs_n), 32'd0);
      chk("R5", "address held in hold", 32'(mem_addr), 32'(ad));
      @(negedge clk);
      chk("R6", "write pulse length", 32'(last_we), 32'(N_WP));
      chk("R9", "ready after write", 32'(host_ready), 32'd1);
    end else begin
      @(negedge clk);
      chk("R2", "oe low in read", 32'(mem_oe_n), 32'd0);
      chk("R2", "we high in read", 32'(mem_we_n), 32'd1);
      while (!host_rvalid) @(negedge clk);
      chk(tag, "read data", 32'(host_rdata), 32'(exp));
      chk("R3", "oe high with valid", 32'(mem_oe_n), 32'd1);
      n = 0;
      while (!host_ready) begin
        n++;
        if (n == 2) chk("R8", "valid single pulse", 32'(host_rvalid), 32'd0);
        if (n == 2) chk("R4", "deselected in turnaround", 32'(mem_cs_n), 32'd1);
        @(negedge clk);
      end
      chk("R4", "turnaround length", 32'(n), 32'(N_TA));
      chk("R3", "oe low length", 32'(last_oe), 32'(N_RD + 1));
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem_w[i] = 16'h0000;
    repeat (3) @(negedge clk);
    idle_levels("R1");
    chk("R1", "ready in reset", 32'(host_ready), 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_en = 1'b1;
    idle_levels("R1");

    for (int k = 0; k < NV; k++) run_txn(VEC[k]);

    // Asynchronous reset in the middle of a write pulse.
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_write = 1'b1; host_mode8 = 1'b0;
    host_mask = 2'b11; host_addr = 20'h5; host_wdata = 16'hBEEF;
    @(negedge clk);
    host_req = 1'b0;
    while (mem_we_n) @(negedge clk);
    model_en = 1'b0;
    #1 rst_n = 1'b0;
    #1 idle_levels("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_en = 1'b1;
    idle_levels("R1");
    chk("R9", "ready after reset", 32'(host_ready), 32'd1);

    // The aborted write must not have reached the memory word.
    run_txn({1'b0, 1'b0, 2'b11, 4'h5, 16'h0000, 16'h0000});

    summary();
    $finish;
  end

endmodule